// File: doc/BRIEF.md
# Timer Slave Mode Controller

This block sits beside a timer counter and decides, cycle by cycle, whether the counter advances, in which direction, and whether the counter-enable bit must be set by hardware. One of several trigger lines is picked by an index. A small mode code then chooses how that line, or a quadrature pair, drives the counter.

Five behaviours are supported. Free running follows the enable bit. Gated counting advances only while the picked line is high. A triggered start sets the enable bit on a rising edge. In encoder mode every edge of either quadrature phase gives one count. In external-clock mode each rising edge of the picked line gives one count. Any other mode code falls back to free running.

All outputs are combinational from the present inputs and one registered copy each of the picked trigger and of the two phases. A one-clock pulse therefore covers the cycle in which the new level is first seen. The counter register, input filtering and polarity control belong to neighbouring logic.

Top module: `trig_slave_ctrl`

## Requirements
- R1: `trig_sel` picks trigger line `trig_in[trig_sel]`. Index 0 is bit 0 and index 3 is bit 3. Lines that are not picked have no effect.
- R2: Mode code 0: `count_en` equals `cen`. `count_dir`, `cen_set` and `cnt_rst` stay low, and trigger edges are ignored.
- R3: Mode code 5 (gated): `count_en` is high only in cycles where `cen` and the picked line are both high.
- R4: Mode code 6 (triggered start): when the picked line is high and was low at the previous clock edge while `cen` is low, `cen_set` is high for that one cycle. `count_en` follows `cen`.
- R5: Mode code 6: a rising edge that arrives while `cen` is already high gives neither `cen_set` nor `cnt_rst`.
- R6: `cnt_rst` pulses in exactly the cycles in which `cen_set` pulses, so a triggered start begins from a cleared count.
- R7: Mode code 3 (encoder): while `cen` is high, a change of exactly one of `enc_a`/`enc_b` since the previous clock edge gives `count_en` for one cycle, which is four counts per phase cycle. A cycle with no change, or with both phases changing, gives no count.
- R8: Mode code 3: `count_dir` is 0 (up) for a step in which A leads B, over the sequence (A,B) 00,10,11,01. It is 1 (down) for the reverse order. `count_dir` is low whenever `count_en` is low.
- R9: Mode code 7 (external clock): `count_en` is high for one cycle per rising edge of the picked line, and only while `cen` is high.
- R10: Mode codes 1, 2 and 4 behave exactly as code 0.
- R11: A trigger line held high produces a single pulse (`cen_set` in code 6, `count_en` in code 7), not one per cycle.
- R12: In every mode, `count_en` is low while `cen` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cen | input | 1 | Counter-enable bit from the timer control register |
| trig_sel | input | 2 | Index of the trigger line in use |
| slave_mode | input | 3 | Mode code (0, 3, 5, 6, 7; others act as 0) |
| trig_in | input | 4 | Trigger lines |
| enc_a | input | 1 | Quadrature phase A |
| enc_b | input | 1 | Quadrature phase B |
| count_en | output | 1 | Counter advances this cycle |
| count_dir | output | 1 | 1 = count down, 0 = count up |
| cen_set | output | 1 | One-cycle request to set the counter-enable bit |
| cnt_rst | output | 1 | One-cycle request to clear the counter |

## Verification
In triggered-start mode the rising edge that raises `cen_set` and `cnt_rst` lands in a cycle where `cen` is still low. A start request and a count can therefore never appear in the same cycle. The bench holds the line high across the cycle where `cen` comes up and expects exactly one start pulse and then plain counting. It then gives a second edge with `cen` already high and expects that edge to be ignored. In encoder mode the bench also changes both phases in one cycle and expects no count in either direction.

// File: rtl/trig_slave_ctrl.sv
module trig_slave_ctrl #(
  parameter int NTRIG = 4,
  localparam int SW = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cen,
  input  logic [SW-1:0]    trig_sel,
  input  logic [2:0]       slave_mode,
  input  logic [NTRIG-1:0] trig_in,
  input  logic             enc_a,
  input  logic             enc_b,
  output logic             count_en,
  output logic             count_dir,
  output logic             cen_set,
  output logic             cnt_rst
);
  localparam logic [2:0] M_FREE = 3'd0;
  localparam logic [2:0] M_ENC  = 3'd3;
  localparam logic [2:0] M_GATE = 3'd5;
  localparam logic [2:0] M_TRIG = 3'd6;
  localparam logic [2:0] M_XCLK = 3'd7;

  logic sel_now, sel_q, a_q, b_q;
  logic rise, enc_step, enc_up;
  logic [2:0] mode;

  assign sel_now = trig_in[trig_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      a_q   <= 1'b0;
      b_q   <= 1'b0;
    end else begin
      sel_q <= sel_now;
      a_q   <= enc_a;
      b_q   <= enc_b;
    end
  end

  assign rise     = sel_now & ~sel_q;
  assign enc_step = (enc_a ^ a_q) ^ (enc_b ^ b_q);
  assign enc_up   = enc_a ^ b_q;

  always_comb begin
    case (slave_mode)
      M_ENC, M_GATE, M_TRIG, M_XCLK: mode = slave_mode;
      default:                       mode = M_FREE;
    endcase
  end

  always_comb begin
    count_en  = 1'b0;
    count_dir = 1'b0;
    cen_set   = 1'b0;
    case (mode)
      M_ENC: begin
        count_en  = cen & enc_step;
        count_dir = cen & enc_step & ~enc_up;
      end
      M_GATE:  count_en = cen & sel_now;
      M_TRIG: begin
        count_en = cen;
        cen_set  = rise & ~cen;
      end
      M_XCLK:  count_en = cen & rise;
      default: count_en = cen;
    endcase
  end

  assign cnt_rst = cen_set;
endmodule

// File: rtl/trig_slave_ctrl_chk.sv
module trig_slave_ctrl_chk #(
  parameter int NTRIG = 4,
  localparam int SW = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cen,
  input logic [SW-1:0]    trig_sel,
  input logic [2:0]       slave_mode,
  input logic [NTRIG-1:0] trig_in,
  input logic             count_en,
  input logic             count_dir,
  input logic             cen_set,
  input logic             cnt_rst
);
  // R12
  p_cnt_needs_cen_r12: assert property (@(posedge clk) disable iff (!rst_n)
    count_en |-> cen);

  // R3
  p_gate_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode == 3'd5 && count_en) |-> trig_in[trig_sel]);

  // R5
  p_set_only_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cen_set |-> (slave_mode == 3'd6 && !cen));

  // R11
  p_set_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cen_set |=> !cen_set);

  // R8
  p_dir_enc_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    count_dir |-> (slave_mode == 3'd3 && count_en));

  // R9
  p_xclk_one_per_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode == 3'd7 && count_en) |=>
      !(slave_mode == 3'd7 && count_en && $stable(trig_sel)));

  // R10
  p_unsup_as_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode == 3'd1 || slave_mode == 3'd2 || slave_mode == 3'd4) |->
      (count_en == cen && !cen_set && !cnt_rst && !count_dir));
endmodule

bind trig_slave_ctrl trig_slave_ctrl_chk #(.NTRIG(NTRIG)) u_chk (
  .clk(clk), .rst_n(rst_n), .cen(cen), .trig_sel(trig_sel),
  .slave_mode(slave_mode), .trig_in(trig_in), .count_en(count_en),
  .count_dir(count_dir), .cen_set(cen_set), .cnt_rst(cnt_rst)
);

// File: tb/trig_slave_ctrl_tb.sv
module trig_slave_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cen = 1'b0;
  logic [1:0] trig_sel = '0;
  logic [2:0] slave_mode = '0;
  logic [3:0] trig_in = '0;
  logic enc_a = 1'b0, enc_b = 1'b0;
  logic count_en, count_dir, cen_set, cnt_rst;

  always #5 clk = ~clk;

  trig_slave_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cen(cen), .trig_sel(trig_sel),
    .slave_mode(slave_mode), .trig_in(trig_in), .enc_a(enc_a), .enc_b(enc_b),
    .count_en(count_en), .count_dir(count_dir), .cen_set(cen_set), .cnt_rst(cnt_rst)
  );

  typedef struct {
    logic [3:0] outs;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic apply(input logic [2:0] md, input logic [1:0] s, input logic [3:0] t,
                       input logic a, input logic b, input logic c,
                       input logic e_en, input logic e_dir, input logic e_set,
                       input logic e_rst, input string tag);
    exp_t e;
    @(negedge clk);
    slave_mode = md; trig_sel = s; trig_in = t; enc_a = a; enc_b = b; cen = c;
    e.outs = {e_en, e_dir, e_set, e_rst};
    e.tag  = tag;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (q.size() > 0) begin
        exp_t e;
        logic [3:0] act;
        e = q.pop_front();
        act = {count_en, count_dir, cen_set, cnt_rst};
        checks++;
        if (act !== e.outs) begin
          errors++;
          $display("FAIL %s: {en,dir,set,rst} actual %b expected %b", e.tag, act, e.outs);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200us;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    //     mode  sel   trig     a  b  cen  en dir set rst
    apply(3'd0, 2'd0, 4'b0000, 0, 0, 0,   0, 0, 0, 0, "R2 reset state idle");
    apply(3'd0, 2'd0, 4'b0000, 0, 0, 1,   1, 0, 0, 0, "R2 free run follows cen");
    apply(3'd0, 2'd0, 4'b1111, 0, 0, 1,   1, 0, 0, 0, "R2 edge ignored");
    apply(3'd5, 2'd0, 4'b0000, 0, 0, 1,   0, 0, 0, 0, "R3 gate low");
    apply(3'd5, 2'd2, 4'b0100, 0, 0, 1,   1, 0, 0, 0, "R3 R1 gate high on line 2");
    apply(3'd5, 2'd1, 4'b0100, 0, 0, 1,   0, 0, 0, 0, "R1 other line not picked");
    apply(3'd5, 2'd2, 4'b0100, 0, 0, 0,   0, 0, 0, 0, "R12 gate needs cen");
    apply(3'd6, 2'd3, 4'b0000, 0, 0, 0,   0, 0, 0, 0, "R4 idle before edge");
    apply(3'd6, 2'd3, 4'b1000, 0, 0, 0,   0, 0, 1, 1, "R4 R6 start pulse");
    apply(3'd6, 2'd3, 4'b1000, 0, 0, 0,   0, 0, 0, 0, "R11 held level no repeat");
    apply(3'd6, 2'd3, 4'b1000, 0, 0, 1,   1, 0, 0, 0, "R4 counting follows cen");
    apply(3'd6, 2'd3, 4'b0000, 0, 0, 1,   1, 0, 0, 0, "R4 line low still counting");
    apply(3'd6, 2'd3, 4'b1000, 0, 0, 1,   1, 0, 0, 0, "R5 edge while running ignored");
    apply(3'd7, 2'd0, 4'b0000, 0, 0, 1,   0, 0, 0, 0, "R9 no edge");
    apply(3'd7, 2'd0, 4'b0001, 0, 0, 1,   1, 0, 0, 0, "R9 edge counts");
    apply(3'd7, 2'd0, 4'b0001, 0, 0, 1,   0, 0, 0, 0, "R11 held level one count");
    apply(3'd7, 2'd0, 4'b0000, 0, 0, 1,   0, 0, 0, 0, "R9 falling no count");
    apply(3'd7, 2'd0, 4'b0001, 0, 0, 0,   0, 0, 0, 0, "R9 R12 edge without cen");
    apply(3'd3, 2'd0, 4'b0000, 0, 0, 1,   0, 0, 0, 0, "R7 no phase change");
    apply(3'd3, 2'd0, 4'b0000, 1, 0, 1,   1, 0, 0, 0, "R7 R8 up 00-10");
    apply(3'd3, 2'd0, 4'b0000, 1, 1, 1,   1, 0, 0, 0, "R7 R8 up 10-11");
    apply(3'd3, 2'd0, 4'b0000, 0, 1, 1,   1, 0, 0, 0, "R7 R8 up 11-01");
    apply(3'd3, 2'd0, 4'b0000, 0, 0, 1,   1, 0, 0, 0, "R7 R8 up 01-00");
    apply(3'd3, 2'd0, 4'b0000, 0, 1, 1,   1, 1, 0, 0, "R8 down 00-01");
    apply(3'd3, 2'd0, 4'b0000, 1, 1, 1,   1, 1, 0, 0, "R8 down 01-11");
    apply(3'd3, 2'd0, 4'b0000, 1, 1, 1,   0, 0, 0, 0, "R7 stable phases");
    apply(3'd3, 2'd0, 4'b0000, 0, 0, 1,   0, 0, 0, 0, "R7 both phases changed");
    apply(3'd3, 2'd0, 4'b0000, 1, 0, 0,   0, 0, 0, 0, "R8 R12 step without cen");
    apply(3'd4, 2'd0, 4'b0001, 0, 0, 1,   1, 0, 0, 0, "R10 code 4 as free run");
    apply(3'd1, 2'd0, 4'b0000, 0, 0, 0,   0, 0, 0, 0, "R10 code 1 as free run");
    apply(3'd2, 2'd0, 4'b0001, 1, 0, 1,   1, 0, 0, 0, "R10 code 2 as free run");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule